// File: doc/BRIEF.md
# Chip-Select Area Decoder

This block sits between an internal bus master and external memories. It compares every 24-bit external address against four programmable windows and drives one active-low select line per window. A window is described by an enable bit, an 8-bit base value that stands for address bits 23 to 16, a two-bit size code, a 4-bit access-type code, a write-permission bit and a bus-width bit.

Windows 0 and 1 are small windows, sized from 64 KB to 512 KB. Windows 2 and 3 are large windows, sized from 1 MB to 8 MB. For every window, the size code clears the low bits of the base value before the compare. When more than one window matches, the lowest-numbered window wins. A write to a window without write permission selects nothing and raises an error pulse. Access-type codes that are not allowed are flagged and leave their window out of the decode. The mask-area code also leaves its window out, but it is not flagged.

Configuration goes through a simple register write port. Each access is decoded and the result is registered, so the outputs appear one clock after the access is presented.

Top module: `csa_decoder`

## Requirements
- R1: After synchronous reset, `cs_n` is 4'hF, and `bus_wide`, `wprot_err` and `type_bad` are 0. All windows are disabled. All base values and configuration bytes are 0.
- R2: When `reg_we` is high, the register named by `reg_kind` takes effect from the next cycle. The `reg_kind` codes are: 0 for the enable byte, where bit i enables window i; 1 for the base of window `reg_win`; 2 for the configuration of window `reg_win`; 3 for nothing. In the enable byte, bits 7..4 are ignored. A disabled window never drives its select low.
- R3: Windows 0 and 1 with size code s (0..3) match when address bits [23:16+s] equal the same bits of the base value. This gives 64, 128, 256 and 512 KB windows.
- R4: Windows 2 and 3 with size code s match when address bits [23:20+s] equal the same bits of the base value. This gives 1, 2, 4 and 8 MB windows. Base bits below that range are ignored.
- R5: An access presented with `acc_valid` high produces its `cs_n` value one cycle later. At most one bit of `cs_n` is ever low. A cycle with `acc_valid` low gives `cs_n` = 4'hF in the next cycle.
- R6: When several enabled windows match, only the lowest-numbered one is selected.
- R7: A write (`acc_write`=1) whose winning window has write permission 0 selects nothing. In that case `wprot_err` is 1 for exactly the following cycle. Reads from that window, and writes to windows with permission, are selected as normal.
- R8: `bus_wide` follows `cs_n` and equals the width bit of the selected window: 1 means 16-bit, 0 means 8-bit. It is 0 when no window is selected.
- R9: Access type 4'b1111 (mask area) removes the window from the decode without setting its `type_bad` bit. A higher-numbered window that matches may then win.
- R10: Access types with bit 3 set other than 1111, and codes of the form 0x1x, are disallowed. Such a window sets `type_bad[i]` and is never selected. Codes 0x0x are normal access.
- R11: The configuration byte is laid out as follows: [3:0] access type, [4] write permission, [5] width bit, [7:6] size code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_kind | input | 2 | Register selector: 0 enable, 1 base, 2 configuration |
| reg_win | input | 2 | Window index for base and configuration writes |
| reg_wdata | input | 8 | Register write data |
| acc_valid | input | 1 | Access present on the address inputs |
| acc_write | input | 1 | Access is a write |
| acc_addr | input | 24 | External bus byte address |
| cs_n | output | 4 | Registered active-low window selects |
| bus_wide | output | 1 | Data width of the selected window (1 = 16-bit) |
| wprot_err | output | 1 | One-cycle write-protection violation pulse |
| type_bad | output | 4 | Per-window disallowed access-type flag |

## Verification
The hardest situation to reach is an address covered by several windows at once. It requires the priority order, the mask-area exclusion and the write-protection rule to act together on the same access. The bench sets up overlapping windows 0 and 1. It then switches window 0 between a normal code, the mask code and a disallowed code, disables it, and withholds its write permission. After each change it checks which line falls, or that no line falls. Size boundaries are covered by choosing base values with low bits set, so that only correct masking lets an address one step outside the window miss.

// File: rtl/csa_pkg.sv
package csa_pkg;

    localparam int unsigned ADDR_W    = 24;
    localparam int unsigned BASE_W    = 8;
    localparam int unsigned NUM_WIN   = 4;
    localparam int unsigned WIN_IDX_W = $clog2(NUM_WIN);
    localparam int unsigned LARGE_LO  = 2;  // first window that uses the large size scale
    localparam int unsigned SMALL_SH  = 0;  // extra low bits dropped for small windows
    localparam int unsigned LARGE_SH  = 4;  // extra low bits dropped for large windows

    typedef enum logic [1:0] {
        RK_ENABLE = 2'd0,
        RK_BASE   = 2'd1,
        RK_CONFIG = 2'd2,
        RK_NONE   = 2'd3
    } reg_kind_e;

    typedef struct packed {
        logic [1:0] size;
        logic       wide;
        logic       wr_ok;
        logic [3:0] acc_type;
    } win_cfg_t;

    typedef enum logic [1:0] {
        AT_NORMAL,
        AT_MASK,
        AT_ILLEGAL
    } acc_class_e;

    function automatic acc_class_e classify(input logic [3:0] t);
        if (t == 4'b1111)
            return AT_MASK;
        else if (t[3] || t[1])
            return AT_ILLEGAL;
        else
            return AT_NORMAL;
    endfunction

    function automatic logic [BASE_W-1:0] base_mask(input logic [3:0] shift, input logic [1:0] code);
        logic [3:0] amt;
        logic [BASE_W-1:0] ones;
        amt  = shift + {2'b00, code};
        ones = '1;
        return ones << amt;
    endfunction

endpackage

// File: rtl/csa_regs.sv
module csa_regs
    import csa_pkg::*;
#(
    parameter int unsigned N_WIN = NUM_WIN
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       reg_we,
    input  logic [1:0]                 reg_kind,
    input  logic [WIN_IDX_W-1:0]       reg_win,
    input  logic [BASE_W-1:0]          reg_wdata,
    output logic [N_WIN-1:0]           win_en,
    output logic [N_WIN-1:0][BASE_W-1:0] win_base,
    output win_cfg_t [N_WIN-1:0]       win_cfg
);

    reg_kind_e kind;
    assign kind = reg_kind_e'(reg_kind);

    always_ff @(posedge clk) begin
        if (rst) begin
            win_en <= '0;
        end else if (reg_we && kind == RK_ENABLE) begin
            win_en <= reg_wdata[N_WIN-1:0];
        end
    end

    for (genvar i = 0; i < N_WIN; i++) begin : g_win_regs
        always_ff @(posedge clk) begin
            if (rst) begin
                win_base[i] <= '0;
                win_cfg[i]  <= '0;
            end else if (reg_we && reg_win == WIN_IDX_W'(i)) begin
                if (kind == RK_BASE)
                    win_base[i] <= reg_wdata;
                else if (kind == RK_CONFIG)
                    win_cfg[i] <= win_cfg_t'(reg_wdata);
            end
        end
    end

endmodule

// File: rtl/csa_win_match.sv
module csa_win_match
    import csa_pkg::*;
#(
    parameter int unsigned SHIFT = SMALL_SH
) (
    input  logic              enable,
    input  logic [BASE_W-1:0] base,
    input  win_cfg_t          cfg,
    input  logic [BASE_W-1:0] addr_hi,
    output logic              hit,
    output logic              illegal
);

    logic [BASE_W-1:0] mask;
    acc_class_e        cls;

    always_comb begin
        mask    = base_mask(4'(SHIFT), cfg.size);
        cls     = classify(cfg.acc_type);
        illegal = (cls == AT_ILLEGAL);
        hit     = enable && (cls == AT_NORMAL) && ((addr_hi & mask) == (base & mask));
    end

endmodule

// File: rtl/csa_prio.sv
module csa_prio
    import csa_pkg::*;
#(
    parameter int unsigned N_WIN = NUM_WIN
) (
    input  logic [N_WIN-1:0]     req,
    output logic [N_WIN-1:0]     grant,
    output logic [WIN_IDX_W-1:0] grant_idx,
    output logic                 any
);

    always_comb begin
        grant     = '0;
        grant_idx = '0;
        any       = 1'b0;
        for (int i = 0; i < N_WIN; i++) begin
            if (req[i] && !any) begin
                grant[i]  = 1'b1;
                grant_idx = WIN_IDX_W'(i);
                any       = 1'b1;
            end
        end
    end

endmodule

// File: rtl/csa_decoder.sv
module csa_decoder
    import csa_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               reg_we,
    input  logic [1:0]         reg_kind,
    input  logic [1:0]         reg_win,
    input  logic [7:0]         reg_wdata,
    input  logic               acc_valid,
    input  logic               acc_write,
    input  logic [23:0]        acc_addr,
    output logic [3:0]         cs_n,
    output logic               bus_wide,
    output logic               wprot_err,
    output logic [3:0]         type_bad
);

    logic [NUM_WIN-1:0]             win_en;
    logic [NUM_WIN-1:0][BASE_W-1:0] win_base;
    win_cfg_t [NUM_WIN-1:0]         win_cfg;

    logic [NUM_WIN-1:0]   hit;
    logic [NUM_WIN-1:0]   illegal;
    logic [NUM_WIN-1:0]   grant;
    logic [WIN_IDX_W-1:0] grant_idx;
    logic                 any_hit;
    logic [BASE_W-1:0]    addr_hi;
    logic                 blocked;

    assign addr_hi = acc_addr[ADDR_W-1 -: BASE_W];

    csa_regs #(.N_WIN(NUM_WIN)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .reg_we    (reg_we),
        .reg_kind  (reg_kind),
        .reg_win   (reg_win),
        .reg_wdata (reg_wdata),
        .win_en    (win_en),
        .win_base  (win_base),
        .win_cfg   (win_cfg)
    );

    for (genvar i = 0; i < NUM_WIN; i++) begin : g_match
        localparam int unsigned SH = (i < LARGE_LO) ? SMALL_SH : LARGE_SH;
        csa_win_match #(.SHIFT(SH)) u_match (
            .enable  (win_en[i] && acc_valid),
            .base    (win_base[i]),
            .cfg     (win_cfg[i]),
            .addr_hi (addr_hi),
            .hit     (hit[i]),
            .illegal (illegal[i])
        );
    end

    csa_prio #(.N_WIN(NUM_WIN)) u_prio (
        .req       (hit),
        .grant     (grant),
        .grant_idx (grant_idx),
        .any       (any_hit)
    );

    assign blocked = any_hit && acc_write && !win_cfg[grant_idx].wr_ok;

    always_ff @(posedge clk) begin
        if (rst) begin
            cs_n      <= '1;
            bus_wide  <= 1'b0;
            wprot_err <= 1'b0;
        end else begin
            cs_n      <= blocked ? '1 : ~grant;
            bus_wide  <= any_hit && !blocked && win_cfg[grant_idx].wide;
            wprot_err <= blocked;
        end
    end

    assign type_bad = illegal;

endmodule

// File: rtl/csa_decoder_chk.sv
module csa_decoder_chk (
    input logic       clk,
    input logic       rst,
    input logic       acc_valid,
    input logic       acc_write,
    input logic [3:0] cs_n,
    input logic       bus_wide,
    input logic       wprot_err,
    input logic [3:0] type_bad,
    input logic [3:0] win_en
);

    AST_ONE_SELECT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(~cs_n)); // R6

    AST_IDLE_NO_SELECT: assert property (@(posedge clk) disable iff (rst)
        !acc_valid |=> (cs_n == 4'hF)); // R5

    AST_WPROT_NO_SELECT: assert property (@(posedge clk) disable iff (rst)
        wprot_err |-> (cs_n == 4'hF)); // R7

    AST_WPROT_FROM_WRITE: assert property (@(posedge clk) disable iff (rst)
        (!acc_valid || !acc_write) |=> !wprot_err); // R7

    AST_WIDE_NEEDS_SELECT: assert property (@(posedge clk) disable iff (rst)
        (cs_n == 4'hF) |-> !bus_wide); // R8

    for (genvar i = 0; i < 4; i++) begin : g_win
        AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (rst)
            !win_en[i] |=> cs_n[i]); // R2
        AST_BADTYPE_QUIET: assert property (@(posedge clk) disable iff (rst)
            type_bad[i] |=> cs_n[i]); // R10
    end

endmodule

bind csa_decoder csa_decoder_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .acc_valid (acc_valid),
    .acc_write (acc_write),
    .cs_n      (cs_n),
    .bus_wide  (bus_wide),
    .wprot_err (wprot_err),
    .type_bad  (type_bad),
    .win_en    (win_en)
);

// File: tb/test_csa_decoder.sv
module test_csa_decoder;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_kind = 2'd0;
    logic [1:0]  reg_win = 2'd0;
    logic [7:0]  reg_wdata = 8'd0;
    logic        acc_valid = 1'b0;
    logic        acc_write = 1'b0;
    logic [23:0] acc_addr = 24'd0;
    logic [3:0]  cs_n;
    logic        bus_wide;
    logic        wprot_err;
    logic [3:0]  type_bad;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    csa_decoder i_csa_decoder (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_kind(reg_kind), .reg_win(reg_win),
        .reg_wdata(reg_wdata), .acc_valid(acc_valid), .acc_write(acc_write),
        .acc_addr(acc_addr), .cs_n(cs_n), .bus_wide(bus_wide),
        .wprot_err(wprot_err), .type_bad(type_bad)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [1:0] kind, input logic [1:0] win, input logic [7:0] data);
        @(negedge clk);
        reg_we = 1'b1; reg_kind = kind; reg_win = win; reg_wdata = data;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    // cfg byte: [7:6] size, [5] wide, [4] write permission, [3:0] type (R11)
    function automatic logic [7:0] cfg(input logic [1:0] sz, input bit wide, input bit wok, input logic [3:0] t);
        return {sz, wide, wok, t};
    endfunction

    task automatic access(input logic [23:0] a, input bit wr, input logic [3:0] exp_cs, input string req);
        @(negedge clk);
        acc_valid = 1'b1; acc_write = wr; acc_addr = a;
        @(negedge clk);
        acc_valid = 1'b0; acc_write = 1'b0;
        check(cs_n === exp_cs, req, 32'(cs_n), 32'(exp_cs));
    endtask

    task automatic t_reset;
        check(cs_n === 4'hF, "R1 cs_n", 32'(cs_n), 32'hF);
        check(bus_wide === 1'b0 && wprot_err === 1'b0, "R1 flags", {30'd0, bus_wide, wprot_err}, 0);
        check(type_bad === 4'h0, "R1 type_bad", 32'(type_bad), 0);
        access(24'h000000, 1'b0, 4'hF, "R1 all windows disabled");
    endtask

    task automatic t_enable;
        wr_reg(2'd1, 2'd0, 8'h12);
        wr_reg(2'd2, 2'd0, cfg(2'd0, 1'b0, 1'b1, 4'h0));
        wr_reg(2'd0, 2'd0, 8'hF0);
        access(24'h123456, 1'b0, 4'hF, "R2 upper enable bits ignored");
        wr_reg(2'd0, 2'd0, 8'h01);
        access(24'h123456, 1'b0, 4'hE, "R2 window0 enabled");
        wr_reg(2'd3, 2'd0, 8'h00);
        access(24'h123456, 1'b0, 4'hE, "R2 kind 3 writes nothing");
        access(24'h123456, 1'b0, 4'hE, "R5 repeat access");
    endtask

    task automatic t_small;
        wr_reg(2'd2, 2'd0, cfg(2'd1, 1'b0, 1'b1, 4'h0));
        access(24'h130000, 1'b0, 4'hE, "R3 128KB inside");
        access(24'h140000, 1'b0, 4'hF, "R3 128KB outside");
        wr_reg(2'd1, 2'd0, 8'h13);
        wr_reg(2'd2, 2'd0, cfg(2'd3, 1'b0, 1'b1, 4'h0));
        access(24'h17FFFF, 1'b0, 4'hE, "R3 512KB top");
        access(24'h180000, 1'b0, 4'hF, "R3 512KB next");
        wr_reg(2'd2, 2'd0, cfg(2'd0, 1'b0, 1'b1, 4'h0));
        access(24'h12FFFF, 1'b0, 4'hF, "R3 64KB below");
        access(24'h13FFFF, 1'b0, 4'hE, "R3 64KB hit");
        wr_reg(2'd0, 2'd0, 8'h00);
    endtask

    task automatic t_large;
        wr_reg(2'd1, 2'd2, 8'h47);
        wr_reg(2'd2, 2'd2, cfg(2'd0, 1'b0, 1'b1, 4'h0));
        wr_reg(2'd0, 2'd0, 8'h04);
        access(24'h400000, 1'b0, 4'hB, "R4 1MB low base bits masked");
        access(24'h4FFFFF, 1'b0, 4'hB, "R4 1MB top");
        access(24'h500000, 1'b0, 4'hF, "R4 1MB outside");
        wr_reg(2'd1, 2'd3, 8'h80);
        wr_reg(2'd2, 2'd3, cfg(2'd3, 1'b0, 1'b1, 4'h0));
        wr_reg(2'd0, 2'd0, 8'h08);
        access(24'hFFFFFF, 1'b0, 4'h7, "R4 8MB hit");
        access(24'h7FFFFF, 1'b0, 4'hF, "R4 8MB miss");
        wr_reg(2'd0, 2'd0, 8'h00);
    endtask

    task automatic t_priority;
        wr_reg(2'd1, 2'd0, 8'h20);
        wr_reg(2'd2, 2'd0, cfg(2'd0, 1'b1, 1'b0, 4'h0));
        wr_reg(2'd1, 2'd1, 8'h20);
        wr_reg(2'd2, 2'd1, cfg(2'd1, 1'b0, 1'b1, 4'h0));
        wr_reg(2'd0, 2'd0, 8'h03);
        access(24'h200010, 1'b0, 4'hE, "R6 lowest window wins");
        check(bus_wide === 1'b1, "R8 wide window", 32'(bus_wide), 1);
        access(24'h210000, 1'b0, 4'hD, "R6 only window1 covers");
        check(bus_wide === 1'b0, "R8 byte window", 32'(bus_wide), 0);
        wr_reg(2'd0, 2'd0, 8'h02);
        access(24'h200010, 1'b0, 4'hD, "R6 window0 disabled");
        wr_reg(2'd0, 2'd0, 8'h03);
    endtask

    task automatic t_wprot;
        access(24'h200000, 1'b1, 4'hF, "R7 protected write");
        check(wprot_err === 1'b1, "R7 error pulse", 32'(wprot_err), 1);
        check(bus_wide === 1'b0, "R8 none selected", 32'(bus_wide), 0);
        @(negedge clk);
        check(wprot_err === 1'b0, "R7 pulse one cycle", 32'(wprot_err), 0);
        access(24'h200000, 1'b0, 4'hE, "R7 read allowed");
        access(24'h210000, 1'b1, 4'hD, "R7 permitted write");
        check(wprot_err === 1'b0, "R7 no error", 32'(wprot_err), 0);
    endtask

    task automatic t_types;
        wr_reg(2'd2, 2'd0, cfg(2'd0, 1'b1, 1'b1, 4'hF));
        access(24'h200000, 1'b0, 4'hD, "R9 mask area skipped");
        check(type_bad === 4'h0, "R9 mask not flagged", 32'(type_bad), 0);
        wr_reg(2'd2, 2'd0, cfg(2'd0, 1'b1, 1'b1, 4'h2));
        check(type_bad === 4'h1, "R10 0x1x flagged", 32'(type_bad), 1);
        access(24'h200000, 1'b0, 4'hD, "R10 illegal skipped");
        wr_reg(2'd2, 2'd0, cfg(2'd0, 1'b1, 1'b1, 4'h8));
        check(type_bad === 4'h1, "R10 1000 flagged", 32'(type_bad), 1);
        wr_reg(2'd2, 2'd0, cfg(2'd0, 1'b1, 1'b1, 4'h5));
        check(type_bad === 4'h0, "R10 0x0x normal", 32'(type_bad), 0);
        access(24'h200000, 1'b0, 4'hE, "R11 type 0101 selects");
        @(negedge clk);
        check(cs_n === 4'hF, "R5 idle cycle", 32'(cs_n), 32'hF);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_enable();
        t_small();
        t_large();
        t_priority();
        t_wprot();
        t_types();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule